// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the combinational integer datapath of a small RISC core. Each cycle it takes two operand words, a shift count and an operation code. It returns a result word, an overflow exception flag and a write-enable for the destination register. The operations are addition and subtraction, bitwise AND, OR and NOT, and three shifts: left logical, right logical and right arithmetic.

Addition and subtraction each exist in two forms. The trapping form flags two's-complement overflow. When it does, it drops the write-enable so the destination register keeps its old value. The plain form produces the same bits and never raises the flag.

Immediate addition needs no separate code: the decoder sign-extends the constant onto `b_i` and selects the trapping or plain add. The exception handler, the register file and operand decode all sit outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: For op codes 0 (trapping add), 1 (plain add), 2 (trapping subtract) and 3 (plain subtract), `res_o` is `a_i + b_i` or `a_i - b_i` modulo 2^DATA_W. This holds when `b_i` carries a sign-extended negative constant such as 0xFFFFFFF6 (-10).
- R2: Op code 0 raises `ovf_o` exactly when `a_i` and `b_i` share a sign bit and the sign bit of the sum differs from it.
- R3: Op code 2 raises `ovf_o` exactly when the sign bits of `a_i` and `b_i` differ and the sign bit of the difference differs from that of `a_i`.
- R4: Op codes 1 and 3 never raise `ovf_o`, and their `res_o` equals that of codes 0 and 2 for the same operands.
- R5: `we_o` is low whenever `ovf_o` is high. `we_o` is high for every defined op code (0 to 9) that does not overflow.
- R6: Op code 4 gives `a_i & b_i` and op code 5 gives `a_i | b_i`.
- R7: Op code 6 gives `~a_i`, and the value of `b_i` has no effect on `res_o`.
- R8: Op code 7 shifts `a_i` left by `shamt_i`. Zeros enter at the low end and bits leaving the top are lost (0x00000002 by 2 gives 0x00000008).
- R9: Op code 8 shifts `a_i` right by `shamt_i`, with zeros entering at the top.
- R10: Op code 9 shifts `a_i` right by `shamt_i`, with copies of bit DATA_W-1 entering at the top and no rounding correction (0xFFFFFFE7 by 4 gives 0xFFFFFFFE).
- R11: For op codes 7, 8 and 9, a `shamt_i` of 0 returns `a_i` unchanged.
- R12: Op codes 10 to 15 are undefined. They give `res_o` = 0, `ovf_o` = 0 and `we_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | DATA_W | First operand; the only operand used by NOT and by the shifts |
| b_i | input | DATA_W | Second operand, or an already sign-extended immediate |
| shamt_i | input | $clog2(DATA_W) | Shift count |
| op_i | input | 4 | Operation code (0 to 9 defined) |
| res_o | output | DATA_W | Result word |
| ovf_o | output | 1 | Overflow exception from a trapping add or subtract |
| we_o | output | 1 | Destination register write-enable |

## Verification
The bench builds the unit at its default DATA_W of 32, so the shift count is 5 bits wide. This lets the bench drive every shift count from 0 to 31 on a negative and on a positive operand.

The word width puts the sign-boundary operands 0x7FFFFFFF and 0x80000000 in reach. The bench sends them through both the trapping and the plain forms, where overflow and wrap-around must agree on the bits and differ only on the flag. It also covers the -25 arithmetic-shift case, a -10 immediate, NOT with two opposite `b_i` values, and the undefined codes.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_T  = 4'd0,
    OP_ADD_P  = 4'd1,
    OP_SUB_T  = 4'd2,
    OP_SUB_P  = 4'd3,
    OP_AND    = 4'd4,
    OP_OR     = 4'd5,
    OP_NOT    = 4'd6,
    OP_SHL    = 4'd7,
    OP_SHR_L  = 4'd8,
    OP_SHR_A  = 4'd9
  } exec_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;

  typedef enum logic [1:0] {
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHIFT,
    UNIT_NONE
  } unit_sel_e;
endpackage

// File: rtl/exec_addsub.sv
module exec_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              trap_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              ovf_raw;

  // subtract as a + ~b + 1, sharing one adder
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

  assign ovf_raw = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign ovf_o   = trap_i & ovf_raw;
endmodule

// File: rtl/exec_logic.sv
module exec_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]      a_i,
  input  logic [DATA_W-1:0]      b_i,
  input  int_exec_pkg::exec_op_e op_i,
  output logic [DATA_W-1:0]      res_o
);
  import int_exec_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOT:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic              fill;
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;

  // left shift = right shift on the bit-reversed word
  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      rev_in[i] = a_i[DATA_W-1-i];
    end
  end

  assign fill     = arith_i & ~left_i & a_i[DATA_W-1];
  assign stage[0] = left_i ? rev_in : a_i;

  for (genvar s = 0; s < int'(SHAMT_W); s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stage[s+1] = shamt_i[s] ? {{SH{fill}}, stage[s][DATA_W-1:SH]} : stage[s];
  end

  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      rev_out[i] = stage[SHAMT_W][DATA_W-1-i];
    end
  end

  assign res_o = left_i ? rev_out : stage[SHAMT_W];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [3:0]         op_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               ovf_o,
  output logic               we_o
);
  import int_exec_pkg::*;

  exec_op_e          op;
  unit_sel_e         unit;
  logic              is_sub;
  logic              is_trap;
  logic              is_left;
  logic              is_arith;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic              arith_ovf;

  assign op = exec_op_e'(op_i);

  always_comb begin
    unit     = UNIT_NONE;
    is_sub   = 1'b0;
    is_trap  = 1'b0;
    is_left  = 1'b0;
    is_arith = 1'b0;
    case (op_i)
      OP_ADD_T: begin unit = UNIT_ARITH; is_trap = 1'b1; end
      OP_ADD_P: begin unit = UNIT_ARITH; end
      OP_SUB_T: begin unit = UNIT_ARITH; is_sub = 1'b1; is_trap = 1'b1; end
      OP_SUB_P: begin unit = UNIT_ARITH; is_sub = 1'b1; end
      OP_AND, OP_OR, OP_NOT: unit = UNIT_LOGIC;
      OP_SHL:   begin unit = UNIT_SHIFT; is_left = 1'b1; end
      OP_SHR_L: unit = UNIT_SHIFT;
      OP_SHR_A: begin unit = UNIT_SHIFT; is_arith = 1'b1; end
      default:  unit = UNIT_NONE;
    endcase
  end

  exec_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (is_sub),
    .trap_i (is_trap),
    .sum_o  (arith_res),
    .ovf_o  (arith_ovf)
  );

  exec_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op),
    .res_o (logic_res)
  );

  exec_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .a_i     (a_i),
    .shamt_i (shamt_i),
    .left_i  (is_left),
    .arith_i (is_arith),
    .res_o   (shift_res)
  );

  always_comb begin
    unique case (unit)
      UNIT_ARITH: res_o = arith_res;
      UNIT_LOGIC: res_o = logic_res;
      UNIT_SHIFT: res_o = shift_res;
      default:    res_o = '0;
    endcase
  end

  assign ovf_o = (unit == UNIT_ARITH) & arith_ovf;
  // a trap blocks the register write
  assign we_o  = (unit != UNIT_NONE) & ~ovf_o;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  a_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [3:0]         op_i,
  input logic [DATA_W-1:0]  res_o,
  input logic               ovf_o,
  input logic               we_o
);
  import int_exec_pkg::*;

  always_comb begin
    // R5
    wen_block_chk: assert (!(ovf_o && we_o));
    // R4
    no_overflow_chk: assert (!((op_i == OP_ADD_P || op_i == OP_SUB_P) && ovf_o));
    // R11
    shift_zero_chk: assert (!((op_i == OP_SHL || op_i == OP_SHR_L || op_i == OP_SHR_A)
                              && shamt_i == '0) || res_o == a_i);
    // R10
    sra_sign_chk: assert (op_i != OP_SHR_A || res_o[DATA_W-1] == a_i[DATA_W-1]);
    // R8
    shl_fill_chk: assert (!(op_i == OP_SHL && shamt_i != '0) || !res_o[0]);
    // R9
    shr_fill_chk: assert (!(op_i == OP_SHR_L && shamt_i != '0) || !res_o[DATA_W-1]);
    // R12
    undef_quiet_chk: assert (op_i <= OP_LAST || (!we_o && !ovf_o && res_o == '0));
  end
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .a_i     (a_i),
  .shamt_i (shamt_i),
  .op_i    (op_i),
  .res_o   (res_o),
  .ovf_o   (ovf_o),
  .we_o    (we_o)
);

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  localparam int unsigned DATA_W = 32;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        we;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [3:0]  op_i = 4'd15;
  logic [31:0] res_o;
  logic        ovf_o;
  logic        we_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  int_exec_unit #(.DATA_W(DATA_W)) u_int_exec_unit (
    .a_i     (a_i),
    .b_i     (b_i),
    .shamt_i (shamt_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .ovf_o   (ovf_o),
    .we_o    (we_o)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [4:0] sh, input string tag);
    exp_t e;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint wide;
    e.tag = tag; e.ovf = 1'b0; e.we = 1'b1; e.res = '0;
    case (op)
      4'd0, 4'd1: begin
        wide = sa + sb; e.res = a + b;
        e.ovf = (op == 4'd0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4'd2, 4'd3: begin
        wide = sa - sb; e.res = a - b;
        e.ovf = (op == 4'd2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4'd4: e.res = a & b;
      4'd5: e.res = a | b;
      4'd6: e.res = ~a;
      4'd7: e.res = a << sh;
      4'd8: e.res = a >> sh;
      4'd9: e.res = $unsigned($signed(a) >>> sh);
      default: e.we = 1'b0;
    endcase
    if (e.ovf) e.we = 1'b0;
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input string tag);
    @(posedge clk);
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    q.push_back(model(op, a, b, sh, tag));
  endtask

  task automatic check_val(input string tag, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // monitor: compare at the falling edge, half a cycle after drive
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_val(e.tag, "res", res_o, e.res);
      check_val(e.tag, "ovf", {31'd0, ovf_o}, {31'd0, e.ovf});
      check_val(e.tag, "we", {31'd0, we_o}, {31'd0, e.we});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    drive(4'd15, 32'h0, 32'h0, 5'd0, "R12_idle");
    // R1 / R2 / R4: sign boundary on add
    drive(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, "R2_add_pos_ovf");
    drive(4'd1, 32'h7FFFFFFF, 32'h1, 5'd0, "R4_addu_wrap");
    drive(4'd0, 32'h80000000, 32'h80000000, 5'd0, "R2_add_neg_ovf");
    drive(4'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, "R2_add_mixed");
    drive(4'd0, 32'd20, 32'hFFFFFFF6, 5'd0, "R1_addi_minus10");
    drive(4'd1, 32'd3, 32'hFFFFFFF6, 5'd0, "R1_addiu_minus10");
    // R3 / R4: subtract boundary
    drive(4'd2, 32'h80000000, 32'h1, 5'd0, "R3_sub_ovf");
    drive(4'd3, 32'h80000000, 32'h1, 5'd0, "R4_subu_wrap");
    drive(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, "R3_sub_ovf_pos");
    drive(4'd2, 32'h80000000, 32'h80000000, 5'd0, "R3_sub_same_sign");
    drive(4'd2, 32'd5, 32'd9, 5'd0, "R5_sub_we");
    // R6 / R7
    drive(4'd4, 32'hF0F0A5A5, 32'h0FF0FF00, 5'd0, "R6_and");
    drive(4'd5, 32'hF0F0A5A5, 32'h0FF0FF00, 5'd0, "R6_or");
    drive(4'd6, 32'h12345678, 32'h00000000, 5'd0, "R7_not_b0");
    drive(4'd6, 32'h12345678, 32'hFFFFFFFF, 5'd0, "R7_not_b1");
    // R8 / R9 / R10 / R11
    drive(4'd7, 32'h2, 32'h0, 5'd2, "R8_shl_2");
    drive(4'd7, 32'h80000001, 32'h0, 5'd31, "R8_shl_31");
    drive(4'd8, 32'h80000000, 32'h0, 5'd31, "R9_shr_31");
    drive(4'd9, 32'hFFFFFFE7, 32'h0, 5'd4, "R10_sra_m25");
    drive(4'd9, 32'h7FFFFFFF, 32'h0, 5'd30, "R10_sra_pos");
    drive(4'd7, 32'hDEADBEEF, 32'h0, 5'd0, "R11_shl_0");
    drive(4'd8, 32'hDEADBEEF, 32'h0, 5'd0, "R11_shr_0");
    drive(4'd9, 32'hDEADBEEF, 32'h0, 5'd0, "R11_sra_0");
    for (int s = 0; s < 32; s++) begin
      drive(4'd7, 32'hC3A5_0F81, 32'h0, 5'(s), "R8_sweep");
      drive(4'd8, 32'hC3A5_0F81, 32'h0, 5'(s), "R9_sweep");
      drive(4'd9, 32'hC3A5_0F81, 32'h0, 5'(s), "R10_sweep");
      drive(4'd9, 32'h43A5_0F81, 32'h0, 5'(s), "R10_sweep_pos");
    end
    for (int op = 10; op < 16; op++) begin
      drive(4'(op), 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7, "R12_undef");
    end
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule